// File: doc/BRIEF.md
# Byte-Wide Configuration Register Access over a Two-Wire Serial Bus

This block is the target side of an I2C/SMBus-compatible two-wire link. It gives byte-wide access to a 256-entry configuration register file. SCL and SDA are sampled by a fast system clock. Each line passes through a two-flop synchronizer and a glitch filter. From the filtered levels the block detects start, repeated-start and stop conditions. It then compares the 7-bit device address with a fixed six-bit prefix, `111000`, extended by a strap input. A register pointer, kept across transactions, selects the entry being read or written. The block pulls SDA low for acknowledge bits and for read-data zeros, and otherwise leaves the open-drain line released.

A write carries the register index followed by any number of data bytes. A read first sets the pointer with a write that carries no data. A repeated start, or a stop and a fresh start, then opens the read phase. Each stored write passes through a per-register mask, so protected bits keep their value. Every accepted data byte produces a one-cycle strobe with the stored value. Two decoded controls are exported: a soft-reset pulse and a global output-disable level. A stuck-clock timeout aborts a transfer that hangs with SCL low and releases SDA.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The device answers to address `{6'b111000, addr_lsb}` (0x70 or 0x71). For any other address it does not acknowledge and keeps SDA released for the rest of that transaction, until the next start.
- R2: A write (address byte with R/W bit 0, then register index, then data bytes) gets an acknowledge (SDA low) after every byte. All bytes are transferred most significant bit first.
- R3: The register pointer advances by one after every data byte, on reads and on writes, and wraps from 255 to 0.
- R4: After the pointer is set, a repeated start followed by the address with R/W bit 1 returns register contents MSB first. The block keeps sending until the master leaves the acknowledge bit high, and then releases SDA.
- R5: A read opened by a new start after a stop uses the pointer value left by the previous transaction.
- R6: Registers 0 to RO_LIMIT-1 (default 8) are read-only and hold 0x50 plus their index. Registers 0xF0 to 0xFF accept writes only to bits [3:0], and their upper nibble stays 0. All other registers are fully writable. Protected bits keep their old value when written.
- R7: Writing register 246 with bit 1 set produces a one-cycle `soft_rst_pulse`. Bit 1 of that register is never stored and reads back 0.
- R8: `out_disable` equals bit 4 of register 230.
- R9: If SCL stays low for TIMEOUT_CYC system clocks during a transfer, the block returns to idle, releases SDA and pulses `timeout_evt`. The next transaction works normally.
- R10: Each accepted data byte produces exactly one single-cycle `wr_stb`. `wr_addr` and `wr_data` carry the register index and the value actually stored after masking.
- R11: After reset SDA is released, `out_disable` is 0 and every register holds its reset value.
- R12: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored. It shifts no bit and creates no start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| addr_lsb | input | 1 | Strap selecting the address LSB |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_stb | output | 1 | One-cycle strobe per stored data byte |
| wr_addr | output | 8 | Register index of the stored byte |
| wr_data | output | 8 | Value stored after masking |
| soft_rst_pulse | output | 1 | One-cycle soft reset request |
| out_disable | output | 1 | Global output-disable control level |
| timeout_evt | output | 1 | One-cycle pulse when a stuck transfer is aborted |

## Verification
Some rules are checked on every cycle. The block may change its SDA drive only while filtered SCL is low. Strobes and soft-reset pulses last a single cycle. The soft-reset bit is never stored, and the protected upper nibble stays zero. `out_disable` follows the latest write to register 230. SDA is released whenever a timeout fires.

Other behaviour only the bench scenarios can show. These are address matching and strap selection, pointer persistence and wraparound, and read data order under repeated start versus stop-start. The scenarios also cover recovery after a timeout and immunity to short glitches on either line.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int REG_AW = 8;
    localparam int NREG   = 1 << REG_AW;

    localparam logic [5:0] DEV_ADDR_HI  = 6'b111000;
    localparam logic [7:0] SOFT_RST_REG = 8'd246;
    localparam int         SOFT_RST_BIT = 1;
    localparam logic [7:0] OUT_DIS_REG  = 8'd230;
    localparam int         OUT_DIS_BIT  = 4;
    localparam logic [7:0] PROT_HI_BASE = 8'hF0;
    localparam logic [7:0] RO_ID_BASE   = 8'h50;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_REG,
        ST_ACK_REG,
        ST_WDATA,
        ST_ACK_WR,
        ST_RDATA,
        ST_ACK_RD,
        ST_SKIP
    } link_st_e;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] addr;
        logic [7:0]        data;
    } reg_wr_t;

    // bits a write may change in register a
    function automatic logic [7:0] wr_mask(input logic [REG_AW-1:0] a, input int ro_limit);
        logic [7:0] m;
        if (int'(a) < ro_limit)      m = 8'h00;
        else if (a >= PROT_HI_BASE)  m = 8'h0F;
        else                         m = 8'hFF;
        if (a == SOFT_RST_REG)       m[SOFT_RST_BIT] = 1'b0;
        return m;
    endfunction

    function automatic logic [7:0] rst_val(input logic [REG_AW-1:0] a, input int ro_limit);
        return (int'(a) < ro_limit) ? (RO_ID_BASE + 8'(a)) : 8'h00;
    endfunction

    function automatic logic [7:0] merge_bits(input logic [7:0] old_v,
                                              input logic [7:0] new_v,
                                              input logic [7:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sy;
    logic [CW-1:0]          cnt;
    logic                   smp;

    assign smp = sy[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sy   <= '1;
            cnt  <= '0;
            lvl  <= 1'b1;
            rise <= 1'b0;
            fall <= 1'b0;
        end else begin
            sy   <= {sy[SYNC_STAGES-2:0], din};
            rise <= 1'b0;
            fall <= 1'b0;
            if (smp == lvl) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                cnt  <= '0;
                lvl  <= smp;
                rise <= smp;
                fall <= ~smp;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_cfg_link.sv
module i2c_cfg_link
    import i2c_cfg_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic              addr_lsb,
    input  logic [7:0]        rd_data,
    output logic [REG_AW-1:0] rd_ptr,
    output reg_wr_t           wr_req,
    output logic              sda_oe,
    output logic              timeout_evt
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    link_st_e   st;
    logic [3:0] bit_cnt;
    logic [7:0] sh;
    logic [7:0] tx;
    logic       rnw;
    logic [TW-1:0] tmo_cnt;

    logic start_c, stop_c, tmo_hit, rx_state, byte_done;
    logic [7:0] sh_next;

    assign start_c   = scl_lvl & sda_fall;
    assign stop_c    = scl_lvl & sda_rise;
    assign tmo_hit   = (st != ST_IDLE) && !scl_lvl && (tmo_cnt == TW'(TIMEOUT_CYC - 1));
    assign rx_state  = (st == ST_ADDR) || (st == ST_REG) || (st == ST_WDATA);
    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign sh_next   = {sh[6:0], sda_lvl};

    // clock-low watchdog
    always_ff @(posedge clk) begin
        if (rst || st == ST_IDLE || scl_lvl || tmo_hit) tmo_cnt <= '0;
        else                                            tmo_cnt <= tmo_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            bit_cnt     <= '0;
            sh          <= '0;
            tx          <= '0;
            rnw         <= 1'b0;
            rd_ptr      <= '0;
            sda_oe      <= 1'b0;
            timeout_evt <= 1'b0;
            wr_req      <= '0;
        end else begin
            wr_req.en   <= 1'b0;
            timeout_evt <= 1'b0;
            if (start_c) begin
                st      <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_c) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (tmo_hit) begin
                st          <= ST_IDLE;
                sda_oe      <= 1'b0;
                timeout_evt <= 1'b1;
            end else begin
                if (rx_state && scl_rise) begin
                    sh      <= sh_next;
                    bit_cnt <= bit_cnt + 1'b1;
                end
                case (st)
                    ST_ADDR: if (byte_done) begin
                        bit_cnt <= '0;
                        if (sh[7:1] == {DEV_ADDR_HI, addr_lsb}) begin
                            rnw    <= sh[0];
                            sda_oe <= 1'b1;
                            st     <= ST_ACK_ADDR;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                    ST_ACK_ADDR: if (scl_fall) begin
                        if (rnw) begin
                            tx      <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            bit_cnt <= '0;
                            st      <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_REG;
                        end
                    end
                    ST_REG: if (byte_done) begin
                        bit_cnt <= '0;
                        rd_ptr  <= sh;
                        sda_oe  <= 1'b1;
                        st      <= ST_ACK_REG;
                    end
                    ST_ACK_REG: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= ST_WDATA;
                    end
                    ST_WDATA: if (byte_done) begin
                        bit_cnt     <= '0;
                        wr_req.en   <= 1'b1;
                        wr_req.addr <= rd_ptr;
                        wr_req.data <= sh;
                        rd_ptr      <= rd_ptr + 1'b1;
                        sda_oe      <= 1'b1;
                        st          <= ST_ACK_WR;
                    end
                    ST_ACK_WR: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= ST_WDATA;
                    end
                    ST_RDATA: if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                            rd_ptr  <= rd_ptr + 1'b1;
                            st      <= ST_ACK_RD;
                        end else begin
                            tx      <= {tx[6:0], 1'b0};
                            sda_oe  <= ~tx[6];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_ACK_RD: begin
                        if (scl_rise && sda_lvl) begin
                            st <= ST_SKIP;
                        end else if (scl_fall) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            st     <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
    import i2c_cfg_pkg::*;
#(
    parameter int RO_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr_req,
    input  logic [REG_AW-1:0] rd_ptr,
    output logic [7:0]        rd_data,
    output logic              wr_stb,
    output logic [REG_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              soft_rst_pulse,
    output logic              out_disable
);
    logic [7:0] mem [NREG];
    logic [7:0] merged;

    assign merged = merge_bits(mem[wr_req.addr], wr_req.data, wr_mask(wr_req.addr, RO_LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= rst_val(REG_AW'(i), RO_LIMIT);
            wr_stb         <= 1'b0;
            wr_addr        <= '0;
            wr_data        <= '0;
            soft_rst_pulse <= 1'b0;
        end else begin
            wr_stb         <= wr_req.en;
            soft_rst_pulse <= wr_req.en && (wr_req.addr == SOFT_RST_REG)
                              && wr_req.data[SOFT_RST_BIT];
            if (wr_req.en) begin
                mem[wr_req.addr] <= merged;
                wr_addr          <= wr_req.addr;
                wr_data          <= merged;
            end
        end
    end

    assign rd_data     = mem[rd_ptr];
    assign out_disable = mem[OUT_DIS_REG][OUT_DIS_BIT];
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int RO_LIMIT    = 8,
    parameter int TIMEOUT_CYC = 1_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_lsb,
    output logic       sda_drive_low,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       soft_rst_pulse,
    output logic       out_disable,
    output logic       timeout_evt
);
    localparam int NLINE = 2;   // index 0: SCL, index 1: SDA

    logic [NLINE-1:0] raw, lvl, rise, fall;
    logic             scl_flt;
    logic [7:0]       rd_data;
    logic [REG_AW-1:0] rd_ptr;
    reg_wr_t          wr_req;

    assign raw     = {sda_i, scl_i};
    assign scl_flt = lvl[0];

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .lvl (lvl[g]),
            .rise(rise[g]),
            .fall(fall[g])
        );
    end

    i2c_cfg_link #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_link (
        .clk        (clk),
        .rst        (rst),
        .scl_lvl    (lvl[0]),
        .scl_rise   (rise[0]),
        .scl_fall   (fall[0]),
        .sda_lvl    (lvl[1]),
        .sda_rise   (rise[1]),
        .sda_fall   (fall[1]),
        .addr_lsb   (addr_lsb),
        .rd_data    (rd_data),
        .rd_ptr     (rd_ptr),
        .wr_req     (wr_req),
        .sda_oe     (sda_drive_low),
        .timeout_evt(timeout_evt)
    );

    i2c_cfg_regs #(.RO_LIMIT(RO_LIMIT)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_req        (wr_req),
        .rd_ptr        (rd_ptr),
        .rd_data       (rd_data),
        .wr_stb        (wr_stb),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .soft_rst_pulse(soft_rst_pulse),
        .out_disable   (out_disable)
    );
endmodule

// File: rtl/i2c_cfg_checker.sv
module i2c_cfg_checker
    import i2c_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic       scl_flt,
    input logic       wr_stb,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       soft_rst_pulse,
    input logic       out_disable,
    input logic       timeout_evt
);
    // R2/R4: SDA drive changes only while filtered SCL is low
    p_sda_moves_low_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_flt);

    p_stb_single_r10: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    p_soft_single_r7: assert property (@(posedge clk) disable iff (rst)
        soft_rst_pulse |=> !soft_rst_pulse);

    p_soft_with_write_r7: assert property (@(posedge clk) disable iff (rst)
        soft_rst_pulse |-> (wr_stb && wr_addr == SOFT_RST_REG));

    p_soft_bit_unstored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == SOFT_RST_REG) |-> !wr_data[SOFT_RST_BIT]);

    p_od_follows_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == OUT_DIS_REG) |-> (out_disable == wr_data[OUT_DIS_BIT]));

    p_prot_nibble_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr >= PROT_HI_BASE) |-> (wr_data[7:4] == 4'h0));

    p_tmo_release_r9: assert property (@(posedge clk) disable iff (rst)
        timeout_evt |-> !sda_oe);
endmodule

bind i2c_cfg_slave i2c_cfg_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .sda_oe        (sda_drive_low),
    .scl_flt       (scl_flt),
    .wr_stb        (wr_stb),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .soft_rst_pulse(soft_rst_pulse),
    .out_disable   (out_disable),
    .timeout_evt   (timeout_evt)
);

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;
    localparam int Q   = 12;
    localparam int TMO = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m_low = 1'b0;
    logic strap = 1'b0;
    logic glitch_on = 1'b0;
    logic sda_line;

    logic       sda_oe, wr_stb, soft_rst_pulse, out_disable, timeout_evt;
    logic [7:0] wr_addr, wr_data;

    always #5 clk = ~clk;
    assign sda_line = ~(sda_m_low | sda_oe);

    i2c_cfg_slave #(.TIMEOUT_CYC(TMO)) u_i2c_cfg_slave (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .addr_lsb      (strap),
        .sda_drive_low (sda_oe),
        .wr_stb        (wr_stb),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .soft_rst_pulse(soft_rst_pulse),
        .out_disable   (out_disable),
        .timeout_evt   (timeout_evt)
    );

    typedef struct {logic [7:0] a; logic [7:0] d;} wexp_t;
    wexp_t      wq[$];
    logic [7:0] rq[$];
    logic [7:0] model [256];
    logic [7:0] wbuf [4];
    int n_run = 0, n_fail = 0, soft_cnt = 0, tmo_evts = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // mask rules of R6 and R7
    function automatic logic [7:0] exp_mask(input logic [7:0] a);
        logic [7:0] m;
        if (a < 8'd8)        m = 8'h00;
        else if (a >= 8'hF0) m = 8'h0F;
        else                 m = 8'hFF;
        if (a == 8'd246)     m[1] = 1'b0;
        return m;
    endfunction

    task automatic exp_write(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] m, nv;
        m  = exp_mask(a);
        nv = (model[a] & ~m) | (d & m);
        model[a] = nv;
        wq.push_back('{a, nv});
    endtask

    // monitor: scoreboard for write strobes, pulse counters
    always @(negedge clk) begin
        wexp_t e;
        if (!rst && wr_stb) begin
            if (wq.size() == 0) begin
                chk(1'b0, "R10 unexpected strobe", {16'h0, wr_addr, wr_data}, 32'h0);
            end else begin
                e = wq.pop_front();
                chk(wr_addr == e.a && wr_data == e.d, "R10 strobe", {16'h0, wr_addr, wr_data}, {16'h0, e.a, e.d});
            end
        end
        if (!rst && soft_rst_pulse) soft_cnt++;
        if (!rst && timeout_evt) tmo_evts++;
    end

    task automatic bus_start();
        sda_m_low = 1'b0; scl_m = 1'b1; tick(2*Q);
        sda_m_low = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m_low = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m_low = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m_low = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m_low = 1'b0; tick(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m_low = !b;
        if (glitch_on) begin
            tick(4); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q-5);
        end else begin
            tick(Q);
        end
        scl_m = 1'b1;
        if (glitch_on && b) begin
            tick(Q); sda_m_low = 1'b1; tick(2); sda_m_low = 1'b0; tick(Q-2);
        end else begin
            tick(2*Q);
        end
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m_low = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic get_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!ack);
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [7:0] ra, input int n, input string tag);
        logic ak;
        bus_start();
        put_byte({dev, 1'b0}, ak); chk(ak, {tag, " addr ack"}, ak, 1);
        put_byte(ra, ak);          chk(ak, {tag, " index ack"}, ak, 1);
        for (int i = 0; i < n; i++) begin
            exp_write(ra + 8'(i), wbuf[i]);
            put_byte(wbuf[i], ak);
            chk(ak, {tag, " data ack"}, ak, 1);
        end
        bus_stop();
    endtask

    task automatic read_tail(input logic [6:0] dev, input logic [7:0] ra, input int n, input string tag);
        logic ak;
        logic [7:0] d, e;
        put_byte({dev, 1'b1}, ak); chk(ak, {tag, " read addr ack"}, ak, 1);
        for (int i = 0; i < n; i++) begin
            rq.push_back(model[ra + 8'(i)]);
            get_byte(d, i != n - 1);
            e = rq.pop_front();
            chk(d == e, tag, d, e);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] dev, input logic [7:0] ra, input int n,
                           input bit rstart, input string tag);
        logic ak;
        bus_start();
        put_byte({dev, 1'b0}, ak); chk(ak, {tag, " addr ack"}, ak, 1);
        put_byte(ra, ak);          chk(ak, {tag, " index ack"}, ak, 1);
        if (rstart) bus_rstart();
        else begin bus_stop(); bus_start(); end
        read_tail(dev, ra, n, tag);
    endtask

    initial begin
        logic ak;
        for (int i = 0; i < 256; i++) model[i] = (i < 8) ? 8'(8'h50 + i) : 8'h00;
        tick(10);
        rst = 1'b0;
        tick(5);

        // R11: reset state
        chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
        chk(out_disable == 1'b0, "R11 out_disable", out_disable, 0);
        chk(wr_stb == 1'b0, "R11 no strobe", wr_stb, 0);

        // R4 R6 R11: read-only ids through repeated start
        do_read(7'h70, 8'h00, 3, 1'b1, "R4 repeated-start read");

        // R2 R3 R10: burst write, then R5 stop-start read-back
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
        do_write(7'h70, 8'h10, 3, "R2 burst write");
        do_read(7'h70, 8'h10, 3, 1'b0, "R5 stop-start read");

        // R5: read with no index uses the pointer left behind (0x13)
        bus_start();
        read_tail(7'h70, 8'h13, 1, "R5 pointer kept");

        // R3 R6: wrap from 255 into read-only 0
        wbuf[0] = 8'h12; wbuf[1] = 8'h34;
        do_write(7'h70, 8'hFF, 2, "R3 wrap write");
        do_read(7'h70, 8'hFF, 2, 1'b1, "R3 wrap read");

        // R6: read-only and partly protected registers
        wbuf[0] = 8'hFF;
        do_write(7'h70, 8'h03, 1, "R6 read-only write");
        wbuf[0] = 8'hEE;
        do_write(7'h70, 8'hF3, 1, "R6 protected nibble");
        do_read(7'h70, 8'h03, 1, 1'b1, "R6 read-only readback");
        do_read(7'h70, 8'hF3, 1, 1'b0, "R6 nibble readback");

        // R8: output disable
        wbuf[0] = 8'h10;
        do_write(7'h70, 8'd230, 1, "R8 set");
        chk(out_disable == 1'b1, "R8 out_disable set", out_disable, 1);
        wbuf[0] = 8'hEF;
        do_write(7'h70, 8'd230, 1, "R8 clear");
        chk(out_disable == 1'b0, "R8 out_disable clear", out_disable, 0);

        // R7: soft reset pulse
        wbuf[0] = 8'h0F;
        do_write(7'h70, 8'd246, 1, "R7 soft write");
        chk(soft_cnt == 1, "R7 one pulse", soft_cnt, 1);
        wbuf[0] = 8'h05;
        do_write(7'h70, 8'd246, 1, "R7 no-pulse write");
        chk(soft_cnt == 1, "R7 no extra pulse", soft_cnt, 1);
        do_read(7'h70, 8'd246, 1, 1'b1, "R7 bit1 reads 0");

        // R1: foreign address ignored
        bus_start();
        put_byte({7'h72, 1'b0}, ak); chk(!ak, "R1 foreign nack", ak, 0);
        put_byte(8'h20, ak);         chk(!ak, "R1 stays released", ak, 0);
        put_byte(8'h99, ak);         chk(!ak, "R1 data ignored", ak, 0);
        bus_stop();
        do_read(7'h70, 8'h20, 1, 1'b1, "R1 register untouched");

        // R1: strap selects 0x71
        strap = 1'b1;
        tick(4);
        bus_start();
        put_byte({7'h70, 1'b0}, ak); chk(!ak, "R1 0x70 with strap", ak, 0);
        bus_stop();
        wbuf[0] = 8'h66;
        do_write(7'h71, 8'h40, 1, "R1 strap address");
        do_read(7'h71, 8'h40, 1, 1'b1, "R1 strap readback");
        strap = 1'b0;
        tick(4);

        // R12: short glitches on both lines
        glitch_on = 1'b1;
        wbuf[0] = 8'hB7; wbuf[1] = 8'h4D;
        do_write(7'h70, 8'h50, 2, "R12 glitch write");
        glitch_on = 1'b0;
        do_read(7'h70, 8'h50, 2, 1'b1, "R12 glitch readback");

        // R9: stuck clock timeout
        bus_start();
        for (int i = 7; i >= 1; i--) put_bit(7'h70 >> (i - 1));
        put_bit(1'b0);
        sda_m_low = 1'b0;
        tick(20);
        chk(sda_oe == 1'b1, "R9 ack driven before timeout", sda_oe, 1);
        tick(TMO + 100);
        chk(sda_oe == 1'b0, "R9 sda released", sda_oe, 0);
        chk(tmo_evts == 1, "R9 timeout event", tmo_evts, 1);
        scl_m = 1'b1;
        tick(2*Q);
        wbuf[0] = 8'h5A;
        do_write(7'h70, 8'h61, 1, "R9 recovery write");
        do_read(7'h70, 8'h61, 1, 1'b1, "R9 recovery read");

        tick(20);
        chk(wq.size() == 0, "R10 all strobes seen", wq.size(), 0);
        chk(tmo_evts == 1, "R9 no extra timeout", tmo_evts, 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule